// File: doc/BRIEF.md
# Dual-Path Latching Bus Transceiver

This block moves an 18-bit word in two independent directions, A to B and B to A. Each direction has one storage element whose behaviour is chosen by three plain controls. With latch-enable high, the element is transparent, and the far port shows the near port's input in the same cycle. With latch-enable low, the element holds its contents and loads new data only on an enabled rising edge of the path clock. An active-low output enable decides whether the far port is driven. A released port reads as zero, and its drive flag is low.

The block sits in a synchronous core. Each path clock is treated as a control signal and is sampled by the core clock `clk`. A rising path-clock edge is a core edge that sees the path clock high after it was low at the previous core edge. The data moves in one core cycle per transfer and has no valid/ready handshake, so nothing pushes back. The chip pad logic turns each output and drive-flag pair into a three-state pin.

Top module: `dual_path_xcvr`

## Requirements
- R1: After reset both storage elements hold zero. A released output reads zero, and an enabled output in hold mode reads zero until a capture or a transparent phase occurs.
- R2: While a path's latch-enable is high and its output enable is active, the path output equals the path input in the same cycle, with no register between them.
- R3: When latch-enable goes low, the path keeps the input value sampled at the last core clock edge while it was high. The value stays unchanged while the path clock rests high or low.
- R4: With latch-enable low and clock-enable low (active), a core clock edge that first sees the path clock high loads the path input. The new value shows on the output right after that edge.
- R5: With the active-low clock-enable high, rising path-clock edges leave the stored value unchanged.
- R6: With the output enable high, the output reads zero and the drive flag is 0. With it low, the drive flag is 1 and the output carries the path value.
- R7: The output enable acts only on the output. Captures and transparent loads made while the output is released show up as soon as it is enabled again.
- R8: The B-to-A path follows R2 to R7 with its own controls. Activity on one path never changes the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock, samples all controls |
| rst_n | input | 1 | active-low asynchronous reset |
| a_in | input | 18 | value read from the A-side pins |
| a_out | output | 18 | value for the A-side pins, zero when released |
| a_drv | output | 1 | drive the A-side pins |
| b_in | input | 18 | value read from the B-side pins |
| b_out | output | 18 | value for the B-side pins, zero when released |
| b_drv | output | 1 | drive the B-side pins |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B transparent select |
| ab_pclk | input | 1 | A-to-B path clock |
| ab_pclk_en_n | input | 1 | A-to-B path clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A transparent select |
| ba_pclk | input | 1 | B-to-A path clock |
| ba_pclk_en_n | input | 1 | B-to-A path clock enable, active low |

## Verification
A wrong stored word stays hidden while a path is transparent or released. It shows on the output in the first cycle the path is both in hold mode and enabled, and it stays there until the next capture. A broken edge detector shows one core cycle after the path clock rises: the output either misses the new word or changes on a level instead of an edge. A swapped enable or a leak between paths shows in the same cycle on the drive flag or on the other path's output.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Controls for one direction, all sampled by the core clock
  typedef struct packed {
    logic oe_n;
    logic le;
    logic pclk;
    logic pclk_en_n;
  } path_ctl_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  // Reset to 1 so that a clock already high at reset release is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] flow_o
);
  logic [W-1:0] hold_q;

  // Transparent: keep tracking the input so a falling select freezes it.
  // Hold: load only on a qualified path-clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold_q <= '0;
    else if (le_i || cap_i) hold_q <= d_i;
  end

  assign flow_o = le_i ? d_i : hold_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctl_t    ctl_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         drv_o
);
  logic         pclk_rise;
  logic         cap;
  logic [W-1:0] flow;

  xcvr_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (ctl_i.pclk),
    .rise_o (pclk_rise)
  );

  assign cap = pclk_rise & ~ctl_i.pclk_en_n;

  xcvr_store #(.W(W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_i   (ctl_i.le),
    .cap_i  (cap),
    .d_i    (d_i),
    .flow_o (flow)
  );

  assign drv_o = ~ctl_i.oe_n;
  assign q_o   = ctl_i.oe_n ? '0 : flow;
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_pclk,
  input  logic         ab_pclk_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_pclk,
  input  logic         ba_pclk_en_n
);
  path_ctl_t    ctl [NUM_DIR];
  logic [W-1:0] din [NUM_DIR];
  logic [W-1:0] dout[NUM_DIR];
  logic         drv [NUM_DIR];

  assign ctl[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, pclk: ab_pclk, pclk_en_n: ab_pclk_en_n};
  assign ctl[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, pclk: ba_pclk, pclk_en_n: ba_pclk_en_n};
  assign din[DIR_AB] = a_in;
  assign din[DIR_BA] = b_in;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_i (ctl[d]),
      .d_i   (din[d]),
      .q_o   (dout[d]),
      .drv_o (drv[d])
    );
  end

  assign b_out = dout[DIR_AB];
  assign b_drv = drv[DIR_AB];
  assign a_out = dout[DIR_BA];
  assign a_drv = drv[DIR_BA];
endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_pclk,
  input logic         ab_pclk_en_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_pclk,
  input logic         ba_pclk_en_n
);
  logic ab_ck_q, ba_ck_q;
  logic ab_cap, ba_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_ck_q <= 1'b1;
      ba_ck_q <= 1'b1;
    end else begin
      ab_ck_q <= ab_pclk;
      ba_ck_q <= ba_pclk;
    end
  end

  assign ab_cap = ab_pclk & ~ab_ck_q & ~ab_pclk_en_n;
  assign ba_cap = ba_pclk & ~ba_ck_q & ~ba_pclk_en_n;

  // R2
  ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le && !ab_oe_n |-> b_out == a_in);
  // R8
  ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le && !ba_oe_n |-> a_out == b_in);
  // R6
  ab_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> b_out == '0 && !b_drv);
  // R6
  ba_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> a_out == '0 && !a_drv);
  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ab_cap) && !ab_le && !ab_oe_n |-> b_out == $past(a_in));
  // R8
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ba_cap) && !ba_le && !ba_oe_n |-> a_out == $past(b_in));
  // R3
  ab_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ab_le) && !ab_le && !ab_oe_n |-> b_out == $past(a_in));
  // R3, R5
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_le && $past(!ab_le) && !$past(ab_cap) && !ab_oe_n && $past(!ab_oe_n)
    |-> $stable(b_out));
  // R8
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_le && $past(!ba_le) && !$past(ba_cap) && !ba_oe_n && $past(!ba_oe_n)
    |-> $stable(a_out));
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
  .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
  .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_pclk_en_n(ab_pclk_en_n),
  .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_pclk_en_n(ba_pclk_en_n)
);

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_pclk = 1'b0, ab_pclk_en_n = 1'b1;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_pclk = 1'b0, ba_pclk_en_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_path_xcvr #(.W(W)) i_dual_path_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_pclk_en_n(ab_pclk_en_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_pclk_en_n(ba_pclk_en_n)
  );

  function automatic logic [W-1:0] val(input bit dir, input int k);
    logic [W-1:0] v;
    v = W'(32'h15A3C + k * 32'h0913B);
    return dir ? ~v : v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_oe(input bit dir, input logic v);
    if (dir) ba_oe_n = v; else ab_oe_n = v;
  endtask
  task automatic set_le(input bit dir, input logic v);
    if (dir) ba_le = v; else ab_le = v;
  endtask
  task automatic set_ck(input bit dir, input logic v);
    if (dir) ba_pclk = v; else ab_pclk = v;
  endtask
  task automatic set_en(input bit dir, input logic v);
    if (dir) ba_pclk_en_n = v; else ab_pclk_en_n = v;
  endtask
  task automatic put(input bit dir, input logic [W-1:0] v);
    if (dir) b_in = v; else a_in = v;
  endtask

  task automatic chk(input bit dir, input logic [W-1:0] exp, input logic exp_drv,
                     input string req);
    logic [W-1:0] got;
    logic         gd;
    #1;
    got = dir ? a_out : b_out;
    gd  = dir ? a_drv : b_drv;
    n_cmp++;
    if (got !== exp || gd !== exp_drv) begin
      n_bad++;
      $display("FAIL %s dir=%0d: out=%h drv=%b expected out=%h drv=%b",
               req, dir, got, gd, exp, exp_drv);
    end
  endtask

  // R1: zero after reset, released and enabled
  task automatic t_reset();
    chk(0, '0, 1'b0, "R1");
    chk(1, '0, 1'b0, "R1");
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    chk(0, '0, 1'b1, "R1");
    chk(1, '0, 1'b1, "R1");
  endtask

  // R2: same-cycle flow while transparent
  task automatic t_transparent(input bit dir);
    set_le(dir, 1'b1);
    put(dir, val(dir, 1));
    chk(dir, val(dir, 1), 1'b1, "R2");
    put(dir, val(dir, 2));
    chk(dir, val(dir, 2), 1'b1, "R2");
    step();
    chk(dir, val(dir, 2), 1'b1, "R2");
  endtask

  // R3: freeze on falling select, hold with clock at rest
  task automatic t_latch(input bit dir);
    set_le(dir, 1'b1);
    put(dir, val(dir, 3));
    step();
    set_le(dir, 1'b0);
    put(dir, val(dir, 4));
    chk(dir, val(dir, 3), 1'b1, "R3");
    step(); step();
    chk(dir, val(dir, 3), 1'b1, "R3");
  endtask

  // R4: enabled edge loads, level does not
  task automatic t_capture(input bit dir);
    set_en(dir, 1'b0);
    put(dir, val(dir, 5));
    set_ck(dir, 1'b1);
    chk(dir, val(dir, 3), 1'b1, "R4");
    step();
    chk(dir, val(dir, 5), 1'b1, "R4");
    put(dir, val(dir, 6));
    step(); step();
    chk(dir, val(dir, 5), 1'b1, "R4");
    set_ck(dir, 1'b0);
    step();
    chk(dir, val(dir, 5), 1'b1, "R3");
  endtask

  // R5: disabled edges ignored
  task automatic t_gate(input bit dir);
    set_en(dir, 1'b1);
    put(dir, val(dir, 7));
    set_ck(dir, 1'b1); step();
    set_ck(dir, 1'b0); step();
    chk(dir, val(dir, 5), 1'b1, "R5");
    set_en(dir, 1'b0);
    step();
    chk(dir, val(dir, 5), 1'b1, "R5");
  endtask

  // R6, R7: release, capture while released, re-enable
  task automatic t_oe(input bit dir);
    set_oe(dir, 1'b1);
    chk(dir, '0, 1'b0, "R6");
    put(dir, val(dir, 8));
    set_ck(dir, 1'b1); step();
    set_ck(dir, 1'b0); step();
    chk(dir, '0, 1'b0, "R6");
    set_oe(dir, 1'b0);
    chk(dir, val(dir, 8), 1'b1, "R7");
  endtask

  // R8: one path's activity leaves the other untouched
  task automatic t_indep();
    ab_le = 1'b1;
    a_in  = val(0, 9);
    ab_pclk = 1'b1; step();
    ab_pclk = 1'b0; step();
    chk(0, val(0, 9), 1'b1, "R8");
    chk(1, val(1, 8), 1'b1, "R8");
    ab_le = 1'b0;
    ba_oe_n = 1'b1;
    b_in = val(1, 10);
    ba_pclk = 1'b1; step();
    ba_pclk = 1'b0; step();
    chk(0, val(0, 9), 1'b1, "R8");
    chk(1, '0, 1'b0, "R8");
    ba_oe_n = 1'b0;
    chk(1, val(1, 10), 1'b1, "R8");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    for (int d = 0; d < 2; d++) begin
      t_transparent(d[0]);
      t_latch(d[0]);
      t_capture(d[0]);
      t_gate(d[0]);
      t_oe(d[0]);
    end
    t_indep();
    summary();
  end

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung, out=timeout expected=finish");
    summary();
  end
endmodule